// File: doc/BRIEF.md
# Paged 16-bit to 32-bit management register bridge

This block sits behind an MDIO slave deserialiser and lets a host reach a 32-bit register space with nothing but 16-bit management accesses. Each access arrives as a single-cycle request that carries a PHY address, a register number, a direction and, for writes, 16 bits of data. The block folds three things into a 32-bit word address: a page value the host loads first, the low bits of the PHY address and the register number. It then drives a zero-wait internal register bus.

A 32-bit register is split across an even and odd register pair. The even register holds data bits 15:0 and the odd register holds bits 31:16. The host writes the upper half first and the lower half last. The upper half is only staged, and the whole word reaches the bus in one beat when the lower half lands. Reads go the other way. The lower-half read fetches and snapshots the whole word, so the upper-half read that follows sees the same word even if the target changed between the two accesses. Requests to PHY addresses outside the mapped window have no effect, and reads of them return all ones.

Top module: `mdio_reg_bridge`

## Requirements
- R1: A write to register 0x10 of PHY address 0x1f loads the 9-bit page from data bits 8:0. A read of that register returns the page zero-extended to 16 bits.
- R2: PHY addresses 0x10 to 0x17 are mapped. The word index is {page, PHY address bits 2:0, register number bits 4:1}, and the bus byte address is the word index times four.
- R3: A write to an odd (upper-half) mapped register only stages its data. It causes no bus cycle.
- R4: A write to an even (lower-half) mapped register issues one bus write in the same cycle as the request. When the staged upper half was written to the same word index, the bus write carries {staged upper, written lower}.
- R5: Every lower-half write clears the stage. A lower-half write that has no matching staged upper half writes zero into bits 31:16.
- R6: Every read request gives mii_rd_valid high with mii_rdata on the next cycle. A write request gives mii_rd_valid low on the next cycle. A lower-half read returns bits 15:0 of the word fetched from the bus in the request cycle.
- R7: An upper-half read of the word index captured by the most recent lower-half read returns the captured bits 31:16 without a bus cycle. It then consumes the capture.
- R8: An upper-half read with no matching capture fetches the word from the bus and returns its bits 31:16.
- R9: Writes to unmapped PHY addresses, and to registers of PHY 0x1f other than 0x10, cause no bus cycle and do not change the page. Reads of them return 0xFFFF.
- R10: After reset the page is 0, nothing is staged or captured, mii_rd_valid and mii_rdata are 0, and bus_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mii_req | input | 1 | One-cycle management access request |
| mii_we | input | 1 | 1 = write, 0 = read |
| mii_phy | input | 5 | PHY address of the access |
| mii_reg | input | 5 | Register number of the access |
| mii_wdata | input | 16 | Write data |
| mii_rdata | output | 16 | Read data, valid with mii_rd_valid |
| mii_rd_valid | output | 1 | Read data valid, one cycle after a read request |
| bus_req | output | 1 | Internal bus cycle in this clock |
| bus_we | output | 1 | Internal bus cycle is a write |
| bus_addr | output | 18 | Internal byte address, word aligned |
| bus_wdata | output | 32 | Internal bus write data |
| bus_rdata | input | 32 | Internal bus read data, same cycle |

## Verification
The case that is hardest to reach from the ports is a torn read. The word changes between the lower-half and upper-half reads, and the upper half must still come from the earlier capture. The bench's bus model is an array it can change directly. It reads the lower half, overwrites the target word behind the bridge, and then reads the upper half twice. The first read must return the old bits and the second must return the new ones. A stage and a commit whose word indices differ are reached by writing an upper half to one PHY address and the lower half to another.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;
  localparam int PHY_W  = 5;
  localparam int REG_W  = 5;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;

  localparam logic [PHY_W-1:0] PAGE_PHY = 5'h1f;
  localparam logic [REG_W-1:0] PAGE_REG = 5'h10;
  localparam logic [PHY_W-1:0] MAP_BASE = 5'h10;
  localparam logic [HALF_W-1:0] MISS_DATA = 16'hFFFF;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_PAGE,
    ACC_LO,
    ACC_HI,
    ACC_MISS
  } acc_kind_e;
endpackage

// File: rtl/mdio_bridge_decode.sv
module mdio_bridge_decode
  import mdio_bridge_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int SEL_W  = 3,
  localparam int IDX_W = PAGE_W + SEL_W + REG_W - 1
) (
  input  logic              req,
  input  logic [PHY_W-1:0]  phy,
  input  logic [REG_W-1:0]  regn,
  input  logic [PAGE_W-1:0] page,
  output acc_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);
  // window check: upper PHY bits must equal those of the mapped base
  function automatic logic in_window(input logic [PHY_W-1:0] p);
    return p[PHY_W-1:SEL_W] == MAP_BASE[PHY_W-1:SEL_W];
  endfunction

  // word index built from page, PHY select bits and register pair number
  function automatic logic [IDX_W-1:0] fold_index(input logic [PAGE_W-1:0] pg,
                                                   input logic [PHY_W-1:0] p,
                                                   input logic [REG_W-1:0] r);
    return {pg, p[SEL_W-1:0], r[REG_W-1:1]};
  endfunction

  always_comb begin
    kind = ACC_NONE;
    if (req) begin
      if (phy == PAGE_PHY)      kind = (regn == PAGE_REG) ? ACC_PAGE : ACC_MISS;
      else if (in_window(phy))  kind = regn[0] ? ACC_HI : ACC_LO;
      else                      kind = ACC_MISS;
    end
  end

  assign idx = fold_index(page, phy, regn);
endmodule

// File: rtl/mdio_bridge_wstage.sv
module mdio_bridge_wstage
  import mdio_bridge_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_kind_e         kind,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [HALF_W-1:0] wdata,
  output logic              commit,
  output logic [WORD_W-1:0] commit_data
);
  logic              stg_valid;
  logic [IDX_W-1:0]  stg_idx;
  logic [HALF_W-1:0] stg_hi;
  logic              wr_hi, wr_lo, stg_match;

  assign wr_hi     = we && (kind == ACC_HI);
  assign wr_lo     = we && (kind == ACC_LO);
  assign stg_match = stg_valid && (stg_idx == idx);

  assign commit      = wr_lo;
  assign commit_data = {stg_match ? stg_hi : '0, wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_valid <= 1'b0;
      stg_idx   <= '0;
      stg_hi    <= '0;
    end else if (wr_hi) begin
      stg_valid <= 1'b1;
      stg_idx   <= idx;
      stg_hi    <= wdata;
    end else if (wr_lo) begin
      stg_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_bridge_rsnap.sv
module mdio_bridge_rsnap
  import mdio_bridge_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_kind_e         kind,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] bus_rdata,
  output logic              fetch,
  output logic [HALF_W-1:0] half_out
);
  logic              snap_valid;
  logic [IDX_W-1:0]  snap_idx;
  logic [HALF_W-1:0] snap_hi;
  logic              rd_lo, rd_hi, snap_hit;

  assign rd_lo    = !we && (kind == ACC_LO);
  assign rd_hi    = !we && (kind == ACC_HI);
  assign snap_hit = snap_valid && (snap_idx == idx);
  assign fetch    = rd_lo || (rd_hi && !snap_hit);

  always_comb begin
    if (rd_lo)         half_out = bus_rdata[HALF_W-1:0];
    else if (snap_hit) half_out = snap_hi;
    else               half_out = bus_rdata[WORD_W-1:HALF_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_valid <= 1'b0;
      snap_idx   <= '0;
      snap_hi    <= '0;
    end else if (rd_lo) begin
      snap_valid <= 1'b1;
      snap_idx   <= idx;
      snap_hi    <= bus_rdata[WORD_W-1:HALF_W];
    end else if (rd_hi) begin
      snap_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_reg_bridge.sv
module mdio_reg_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int SEL_W  = 3,
  localparam int IDX_W  = PAGE_W + SEL_W + REG_W - 1,
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mii_req,
  input  logic              mii_we,
  input  logic [PHY_W-1:0]  mii_phy,
  input  logic [REG_W-1:0]  mii_reg,
  input  logic [HALF_W-1:0] mii_wdata,
  output logic [HALF_W-1:0] mii_rdata,
  output logic              mii_rd_valid,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] bus_rdata
);
  acc_kind_e         kind;
  logic [IDX_W-1:0]  idx;
  logic [PAGE_W-1:0] page_q;
  logic              commit, fetch;
  logic [WORD_W-1:0] commit_data;
  logic [HALF_W-1:0] map_half;
  logic [HALF_W-1:0] rd_next;
  // named events for the checker
  logic              hit_map, hit_page;

  assign hit_map  = (kind == ACC_LO) || (kind == ACC_HI);
  assign hit_page = (kind == ACC_PAGE);

  mdio_bridge_decode #(.PAGE_W(PAGE_W), .SEL_W(SEL_W)) u_dec (
    .req(mii_req), .phy(mii_phy), .regn(mii_reg), .page(page_q),
    .kind(kind), .idx(idx)
  );

  mdio_bridge_wstage #(.IDX_W(IDX_W)) u_wst (
    .clk(clk), .rst_n(rst_n), .kind(kind), .we(mii_we), .idx(idx),
    .wdata(mii_wdata), .commit(commit), .commit_data(commit_data)
  );

  mdio_bridge_rsnap #(.IDX_W(IDX_W)) u_rsn (
    .clk(clk), .rst_n(rst_n), .kind(kind), .we(mii_we), .idx(idx),
    .bus_rdata(bus_rdata), .fetch(fetch), .half_out(map_half)
  );

  assign bus_req   = commit || fetch;
  assign bus_we    = commit;
  assign bus_addr  = {idx, 2'b00};
  assign bus_wdata = commit_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  page_q <= '0;
    else if (hit_page && mii_we) page_q <= mii_wdata[PAGE_W-1:0];
  end

  always_comb begin
    unique case (kind)
      ACC_PAGE:       rd_next = HALF_W'(page_q);
      ACC_LO, ACC_HI: rd_next = map_half;
      default:        rd_next = MISS_DATA;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mii_rd_valid <= 1'b0;
      mii_rdata    <= '0;
    end else begin
      mii_rd_valid <= mii_req && !mii_we;
      if (mii_req && !mii_we) mii_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/mdio_bridge_chk.sv
module mdio_bridge_chk #(
  parameter int PAGE_W = 9,
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mii_req,
  input logic              mii_we,
  input logic [4:0]        mii_reg,
  input logic [15:0]       mii_wdata,
  input logic [15:0]       mii_rdata,
  input logic              mii_rd_valid,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              hit_map,
  input logic              hit_page,
  input logic [PAGE_W-1:0] page_q
);
  assert_page_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mii_req && mii_we && hit_page) |=> (page_q == $past(mii_wdata[PAGE_W-1:0])));

  assert_addr_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_addr[ADDR_W-1 -: PAGE_W] == page_q));

  assert_hi_write_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mii_req && mii_we && hit_map && mii_reg[0]) |-> !bus_req);

  assert_commit_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |-> (mii_req && mii_we && hit_map && !mii_reg[0]));

  assert_read_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mii_req && !mii_we) |=> mii_rd_valid);

  assert_write_no_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mii_req && mii_we) |=> !mii_rd_valid);

  assert_miss_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mii_req && !mii_we && !hit_map && !hit_page) |=> (mii_rdata == 16'hFFFF));

  assert_miss_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_map) |-> !bus_req);
endmodule

bind mdio_reg_bridge mdio_bridge_chk #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mii_req(mii_req), .mii_we(mii_we),
  .mii_reg(mii_reg), .mii_wdata(mii_wdata), .mii_rdata(mii_rdata),
  .mii_rd_valid(mii_rd_valid), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .hit_map(hit_map), .hit_page(hit_page), .page_q(page_q)
);

// File: tb/tb_mdio_reg_bridge.sv
module tb_mdio_reg_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mii_req = 1'b0, mii_we = 1'b0;
  logic [4:0]  mii_phy = '0, mii_reg = '0;
  logic [15:0] mii_wdata = '0;
  logic [15:0] mii_rdata;
  logic        mii_rd_valid;
  logic        bus_req, bus_we;
  logic [17:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int checks = 0, fails = 0, bus_cnt = 0;
  logic [31:0] mem [256];
  logic [17:0] last_addr;
  logic [31:0] last_wd;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_reg_bridge dut (
    .clk(clk), .rst_n(rst_n), .mii_req(mii_req), .mii_we(mii_we),
    .mii_phy(mii_phy), .mii_reg(mii_reg), .mii_wdata(mii_wdata),
    .mii_rdata(mii_rdata), .mii_rd_valid(mii_rd_valid),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // zero-wait bus slave, aliased on 8 index bits
  assign bus_rdata = mem[bus_addr[9:2]];
  always @(posedge clk) begin
    if (bus_req) begin
      bus_cnt <= bus_cnt + 1;
      if (bus_we) begin
        mem[bus_addr[9:2]] <= bus_wdata;
        last_addr <= bus_addr;
        last_wd   <= bus_wdata;
      end
    end
  end

  // {we, phy, reg, wdata, expected read}
  localparam logic [42:0] VEC [NVEC] = '{
    {1'b1, 5'h1f, 5'h10, 16'h0003, 16'h0000},
    {1'b0, 5'h1f, 5'h10, 16'h0000, 16'h0003},
    {1'b1, 5'h12, 5'h05, 16'hBEEF, 16'h0000},
    {1'b1, 5'h12, 5'h04, 16'h1234, 16'h0000},
    {1'b0, 5'h12, 5'h04, 16'h0000, 16'h1234},
    {1'b0, 5'h12, 5'h05, 16'h0000, 16'hBEEF},
    {1'b1, 5'h17, 5'h1f, 16'hCAFE, 16'h0000},
    {1'b1, 5'h17, 5'h1e, 16'h0001, 16'h0000},
    {1'b0, 5'h17, 5'h1e, 16'h0000, 16'h0001},
    {1'b0, 5'h17, 5'h1f, 16'h0000, 16'hCAFE},
    {1'b1, 5'h10, 5'h00, 16'h00AA, 16'h0000},
    {1'b0, 5'h10, 5'h01, 16'h0000, 16'h0000},
    {1'b0, 5'h10, 5'h00, 16'h0000, 16'h00AA},
    {1'b0, 5'h08, 5'h00, 16'h0000, 16'hFFFF},
    {1'b1, 5'h18, 5'h00, 16'h5555, 16'h0000},
    {1'b0, 5'h18, 5'h00, 16'h0000, 16'hFFFF},
    {1'b0, 5'h1f, 5'h11, 16'h0000, 16'hFFFF}
  };
  localparam string VTAG [NVEC] = '{
    "R1", "R1", "R3", "R4", "R6", "R7", "R3", "R4", "R6", "R7",
    "R5", "R8", "R6", "R9", "R9", "R9", "R9"
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [4:0] phy, input logic [4:0] rg,
                     input logic [15:0] d, output logic [15:0] rd, output logic v);
    @(negedge clk);
    mii_req = 1'b1; mii_we = we; mii_phy = phy; mii_reg = rg; mii_wdata = d;
    @(negedge clk);
    rd = mii_rdata; v = mii_rd_valid;
    mii_req = 1'b0;
  endtask

  function automatic logic [17:0] exp_addr(input logic [8:0] pg, input logic [4:0] phy,
                                           input logic [4:0] rg);
    int unsigned w;
    w = (32'(pg) * 128) + (32'(phy % 8) * 16) + 32'(rg / 2);
    return 18'(w * 4);
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] rd;
    logic v;
    int cnt0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", {31'b0, mii_rd_valid}, 32'd0);
    check("R10", {16'b0, mii_rdata}, 32'd0);
    check("R10", {31'b0, bus_req}, 32'd0);
    rst_n = 1'b1;
    acc(1'b0, 5'h1f, 5'h10, 16'h0, rd, v);
    check("R10", {16'b0, rd}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      acc(VEC[i][42], VEC[i][41:37], VEC[i][36:32], VEC[i][31:16], rd, v);
      if (!VEC[i][42]) check(VTAG[i], {16'b0, rd}, {16'b0, VEC[i][15:0]});
    end

    // R7 / R8: torn read across a change of the target word
    acc(1'b0, 5'h12, 5'h04, 16'h0, rd, v);
    check("R6", {31'b0, v}, 32'd1);
    check("R6", {16'b0, rd}, 32'h1234);
    @(negedge clk); mem[8'hA2] = 32'h7777_4321;
    cnt0 = bus_cnt;
    acc(1'b0, 5'h12, 5'h05, 16'h0, rd, v);
    check("R7", {16'b0, rd}, 32'hBEEF);
    check("R7", bus_cnt, cnt0);
    acc(1'b0, 5'h12, 5'h05, 16'h0, rd, v);
    check("R8", {16'b0, rd}, 32'h7777);

    // R5: mismatched stage, then cleared stage
    acc(1'b1, 5'h12, 5'h05, 16'h1111, rd, v);
    acc(1'b1, 5'h13, 5'h04, 16'h2222, rd, v);
    check("R5", last_wd, 32'h0000_2222);
    check("R2", {14'b0, last_addr}, {14'b0, exp_addr(9'h003, 5'h13, 5'h04)});
    acc(1'b1, 5'h12, 5'h04, 16'h3333, rd, v);
    check("R5", last_wd, 32'h0000_3333);

    // R3 / R4: staged write makes exactly one bus beat
    cnt0 = bus_cnt;
    acc(1'b1, 5'h14, 5'h09, 16'hABCD, rd, v);
    check("R3", bus_cnt, cnt0);
    check("R6", {31'b0, v}, 32'd0);
    acc(1'b1, 5'h14, 5'h08, 16'h0F0F, rd, v);
    check("R4", last_wd, 32'hABCD_0F0F);
    check("R4", bus_cnt, cnt0 + 1);

    // R2: full page folding
    acc(1'b1, 5'h1f, 5'h10, 16'hFFAB, rd, v);
    acc(1'b0, 5'h1f, 5'h10, 16'h0, rd, v);
    check("R1", {16'b0, rd}, 32'h01AB);
    acc(1'b1, 5'h15, 5'h0d, 16'h9999, rd, v);
    acc(1'b1, 5'h15, 5'h0c, 16'h8888, rd, v);
    check("R2", {14'b0, last_addr}, {14'b0, exp_addr(9'h1AB, 5'h15, 5'h0c)});
    check("R4", last_wd, 32'h9999_8888);

    // R9: ignored writes leave bus and page untouched
    cnt0 = bus_cnt;
    acc(1'b1, 5'h18, 5'h02, 16'h1234, rd, v);
    acc(1'b1, 5'h1f, 5'h12, 16'h0055, rd, v);
    check("R9", bus_cnt, cnt0);
    acc(1'b0, 5'h1f, 5'h10, 16'h0, rd, v);
    check("R9", {16'b0, rd}, 32'h01AB);

    finish_run();
  end
endmodule